// File: doc/BRIEF.md
# Two-Wire Register Read Target

This block is a target on a two-wire serial bus. It gives a bus controller read access to a small array of byte registers that sit outside the block. The clock and data lines come in as plain inputs and are sampled by the system clock. The block pulls the data line low through a single open-drain enable. The block watches for start and stop conditions and compares the 7-bit device address. During a write phase it takes a two-byte register address and keeps it in an internal counter. Each byte it returns is read from an external register file through a combinational read port.

A random read is done in two parts. First comes a write phase that carries the two address bytes. Then comes a repeated start with the read bit set. If a stop ends the write phase instead, the address counter is still set, so the next current-address read starts from that location. Each byte the controller acknowledges is followed by the next register. When the counter passes the last register it goes back to register zero. A not-acknowledge, a stop or an unmatched address puts the block in standby, and it ignores the bus until the next start.

Top module: `i2c_regread_target`

## Requirements
- R1: A device byte whose upper seven bits are 1101111 is acknowledged (SDA pulled low in the ninth clock). Any other address gets no acknowledge, and the block does not drive SDA until the next START.
- R2: A START (SDA falling while SCL is high) seen at any point restarts reception of a device byte, and any partly received byte is dropped.
- R3: After reset, and after any STOP (SDA rising while SCL is high), the block is in standby with SDA released.
- R4: In a write phase the block acknowledges two register-address bytes, high byte first. Only the low log2(NREGS) bits of the 16-bit value are loaded into the address counter.
- R5: A repeated START with the read bit (bit 0 = 1) after the address bytes returns the byte stored at the loaded address.
- R6: A STOP right after the address bytes still loads the counter. A following current-address read, with no address bytes, returns the byte at that address.
- R7: Each data byte sent moves the counter forward by one, so an acknowledged byte at address n is followed by the byte at n+1.
- R8: After address NREGS-1 the counter wraps to 0, and data keeps coming for each acknowledge.
- R9: A not-acknowledge from the controller ends the read. Further SCL pulses without a START get no drive on SDA.
- R10: SDA drive changes only while SCL is low.
- R11: Data is sent MSB first. SDA is pulled low only for acknowledge bits and for zero data bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples the bus |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Serial clock line as seen at the pad |
| sda_i | input | 1 | Serial data line as seen at the pad |
| sda_oe | output | 1 | 1 pulls SDA low (open-drain enable) |
| reg_addr | output | log2(NREGS) | Read address into the register file |
| reg_data | input | 8 | Byte returned by the register file for reg_addr |

## Verification
The register file model holds a distinct value at every address, so a byte from the wrong address, or a byte shifted by one bit, is caught. Random reads start at two locations with different high address bytes, which shows that only the low bits index the array. A sequence of a stop-terminated address write followed by a current-address read separates "address loaded" from "address loaded only on repeated start". A four-byte run that crosses the top of the array separates correct wrapping from running past the end. A wrong address, clocking after a not-acknowledge, and a start that breaks into a partial byte each test a case where the block must stay silent or start over. A monitor flags any change of drive while SCL is high.

// File: rtl/i2crr_pkg.sv
// Shared types for the two-wire register read target.
// Assumes nothing beyond IEEE 1800-2017 enum support.
package i2crr_pkg;

    // Bit-level link state of the target.
    typedef enum logic [2:0] {
        ST_IDLE,   // standby, waiting for START
        ST_RX,     // shifting in a byte from the controller
        ST_ACK,    // holding SDA low for an acknowledge
        ST_TX,     // shifting out a data byte
        ST_MACK    // sampling the controller's acknowledge
    } link_state_t;

    // Which byte of a write phase is being received.
    typedef enum logic [1:0] {
        PH_DEV,    // device address + R/W
        PH_AHI,    // register address, high byte
        PH_ALO     // register address, low byte
    } phase_t;

endpackage

// File: rtl/i2crr_line_sync.sv
// Brings SCL and SDA into the clock domain and finds edges and bus conditions.
// Assumes the lines are slow compared with clk (several clk per SCL phase).
// Sync registers reset to 1, which is the idle level of the bus.
module i2crr_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [STAGES-1:0] scl_pipe;
    logic [STAGES-1:0] sda_pipe;
    logic              scl_d;
    logic              sda_d;
    logic              scl_s;

    // Synchronizer chains for both lines.
    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    scl_pipe <= '1;
                    sda_pipe <= '1;
                end else begin
                    scl_pipe <= scl_i;
                    sda_pipe <= sda_i;
                end
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    scl_pipe <= '1;
                    sda_pipe <= '1;
                end else begin
                    scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
                    sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
                end
            end
        end
    endgenerate

    // One-cycle delayed copies used for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_d <= 1'b1;
            sda_d <= 1'b1;
        end else begin
            scl_d <= scl_s;
            sda_d <= sda_s;
        end
    end

    assign scl_s     = scl_pipe[STAGES-1];
    assign sda_s     = sda_pipe[STAGES-1];
    assign scl_rise  = scl_s & ~scl_d;
    assign scl_fall  = ~scl_s & scl_d;
    assign start_det = scl_s & scl_d & sda_d & ~sda_s;
    assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;

endmodule

// File: rtl/i2crr_addr_ctr.sv
// Register address counter: loaded from the write phase, stepped after each
// byte sent, wrapping from NREGS-1 to 0. Assumes load and step never coincide.
module i2crr_addr_ctr #(
    parameter int NREGS = 64,
    parameter int AW    = $clog2(NREGS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] load_val,
    input  logic          step,
    output logic [AW-1:0] addr
);
    localparam logic [AW-1:0] LAST = AW'(NREGS - 1);

    logic [AW-1:0] cnt_q;

    // Load, step with wrap, or hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (step) begin
            cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
        end
    end

    assign addr = cnt_q;

    // R8
    wrap_to_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load && addr == LAST) |=> (addr == '0));

    // R7
    step_by_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load && addr != LAST) |=> (addr == $past(addr) + 1'b1));

endmodule

// File: rtl/i2crr_link_fsm.sv
// Byte-level protocol engine. It receives the device and address bytes,
// drives acknowledges, shifts data out MSB first and samples the
// controller's acknowledge. Assumes the event inputs are single-cycle
// pulses from i2crr_line_sync. SDA drive changes only on SCL falling
// events, or when a bus condition clears it.
module i2crr_link_fsm
    import i2crr_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'b1101111,
    parameter int         AW       = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sda_s,
    input  logic          scl_rise,
    input  logic          scl_fall,
    input  logic          start_det,
    input  logic          stop_det,
    input  logic [7:0]    rd_byte,
    output logic          sda_oe,
    output logic          ctr_load,
    output logic [AW-1:0] ctr_val,
    output logic          ctr_step
);
    link_state_t state_q;
    phase_t      phase_q;
    logic [3:0]  bitcnt_q;
    logic [7:0]  shreg_q;
    logic [7:0]  ahi_q;
    logic        rd_q;
    logic        mack_q;
    logic        oe_q;
    logic        load_q;
    logic        step_q;
    logic [15:0] addr_full;
    logic        unused_addr_bits;

    assign addr_full        = {ahi_q, shreg_q};
    assign unused_addr_bits = ^addr_full;

    // Main protocol state machine: bus conditions first, then the bit rules.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            phase_q  <= PH_DEV;
            bitcnt_q <= '0;
            shreg_q  <= '0;
            ahi_q    <= '0;
            rd_q     <= 1'b0;
            mack_q   <= 1'b0;
            oe_q     <= 1'b0;
            load_q   <= 1'b0;
            step_q   <= 1'b0;
        end else begin
            load_q <= 1'b0;
            step_q <= 1'b0;
            if (start_det) begin
                state_q  <= ST_RX;
                phase_q  <= PH_DEV;
                bitcnt_q <= '0;
                oe_q     <= 1'b0;
            end else if (stop_det) begin
                state_q <= ST_IDLE;
                oe_q    <= 1'b0;
            end else begin
                unique case (state_q)
                    ST_IDLE: ;
                    ST_RX: begin
                        if (scl_rise && bitcnt_q < 4'd8) begin
                            shreg_q  <= {shreg_q[6:0], sda_s};
                            bitcnt_q <= bitcnt_q + 4'd1;
                        end else if (scl_fall && bitcnt_q == 4'd8) begin
                            unique case (phase_q)
                                PH_DEV: begin
                                    if (shreg_q[7:1] == DEV_ADDR) begin
                                        state_q <= ST_ACK;
                                        oe_q    <= 1'b1;
                                        rd_q    <= shreg_q[0];
                                    end else begin
                                        state_q <= ST_IDLE;
                                    end
                                end
                                PH_AHI: begin
                                    ahi_q   <= shreg_q;
                                    state_q <= ST_ACK;
                                    oe_q    <= 1'b1;
                                end
                                default: begin
                                    load_q  <= 1'b1;
                                    state_q <= ST_ACK;
                                    oe_q    <= 1'b1;
                                end
                            endcase
                        end
                    end
                    ST_ACK: begin
                        if (scl_fall) begin
                            bitcnt_q <= '0;
                            if (rd_q && phase_q == PH_DEV) begin
                                state_q <= ST_TX;
                                shreg_q <= rd_byte;
                                oe_q    <= ~rd_byte[7];
                            end else begin
                                oe_q <= 1'b0;
                                unique case (phase_q)
                                    PH_DEV:  begin phase_q <= PH_AHI; state_q <= ST_RX; end
                                    PH_AHI:  begin phase_q <= PH_ALO; state_q <= ST_RX; end
                                    default: state_q <= ST_IDLE;
                                endcase
                            end
                        end
                    end
                    ST_TX: begin
                        if (scl_fall) begin
                            if (bitcnt_q == 4'd7) begin
                                oe_q    <= 1'b0;
                                step_q  <= 1'b1;
                                mack_q  <= 1'b0;
                                state_q <= ST_MACK;
                            end else begin
                                bitcnt_q <= bitcnt_q + 4'd1;
                                shreg_q  <= {shreg_q[6:0], 1'b0};
                                oe_q     <= ~shreg_q[6];
                            end
                        end
                    end
                    ST_MACK: begin
                        if (scl_rise) begin
                            mack_q <= ~sda_s;
                        end else if (scl_fall) begin
                            if (mack_q) begin
                                state_q  <= ST_TX;
                                bitcnt_q <= '0;
                                shreg_q  <= rd_byte;
                                oe_q     <= ~rd_byte[7];
                            end else begin
                                state_q <= ST_IDLE;
                            end
                        end
                    end
                    default: state_q <= ST_IDLE;
                endcase
            end
        end
    end

    assign sda_oe   = oe_q;
    assign ctr_load = load_q;
    assign ctr_step = step_q;
    assign ctr_val  = addr_full[AW-1:0];

    // R2
    start_restarts_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> (state_q == ST_RX && bitcnt_q == 4'd0 && !sda_oe));

    // R3
    stop_standby_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_det && !start_det) |=> (state_q == ST_IDLE && !sda_oe));

    // R10
    drive_on_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> $past(scl_fall || start_det || stop_det));

    // R9
    idle_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |-> !sda_oe);

endmodule

// File: rtl/i2c_regread_target.sv
// Top of the two-wire register read target: line synchronizer, protocol
// engine and address counter. Assumes the register file answers reg_data
// combinationally for the address on reg_addr, and that NREGS >= 2.
module i2c_regread_target #(
    parameter int         NREGS       = 64,
    parameter logic [6:0] DEV_ADDR    = 7'b1101111,
    parameter int         SYNC_STAGES = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     scl_i,
    input  logic                     sda_i,
    output logic                     sda_oe,
    output logic [$clog2(NREGS)-1:0] reg_addr,
    input  logic [7:0]               reg_data
);
    localparam int AW = $clog2(NREGS);

    logic          sda_s;
    logic          scl_rise;
    logic          scl_fall;
    logic          start_det;
    logic          stop_det;
    logic          ctr_load;
    logic          ctr_step;
    logic [AW-1:0] ctr_val;

    i2crr_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    i2crr_link_fsm #(.DEV_ADDR(DEV_ADDR), .AW(AW)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det),
        .rd_byte   (reg_data),
        .sda_oe    (sda_oe),
        .ctr_load  (ctr_load),
        .ctr_val   (ctr_val),
        .ctr_step  (ctr_step)
    );

    i2crr_addr_ctr #(.NREGS(NREGS), .AW(AW)) u_ctr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (ctr_load),
        .load_val (ctr_val),
        .step     (ctr_step),
        .addr     (reg_addr)
    );

endmodule

// File: tb/i2c_regread_target_tb.sv
// Directed bench: a bus controller model drives SCL/SDA, and a register file
// model answers with a distinct value at every address.
module i2c_regread_target_tb;
    localparam int NREGS = 64;
    localparam int AW    = 6;
    localparam int Q     = 8;
    localparam logic [7:0] DEV_W = 8'hDE;
    localparam logic [7:0] DEV_R = 8'hDF;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          m_scl = 1'b1;
    logic          m_sda = 1'b1;
    logic          sda_oe;
    logic [AW-1:0] reg_addr;
    logic [7:0]    reg_data;
    logic          sda_bus;

    int total = 0;
    int bad   = 0;
    int hi_changes = 0;
    logic oe_seen = 1'b0;
    logic prev_oe = 1'b0;
    logic done = 1'b0;

    always #2.5 clk = ~clk;

    function automatic logic [7:0] regval(int a);
        return 8'((a * 37 + 11) & 255);
    endfunction

    assign sda_bus  = m_sda & ~sda_oe;
    assign reg_data = regval(int'(reg_addr));

    i2c_regread_target u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (m_scl),
        .sda_i    (sda_bus),
        .sda_oe   (sda_oe),
        .reg_addr (reg_addr),
        .reg_data (reg_data)
    );

    // Drive-change monitor (R10) and drive-seen flag.
    always @(negedge clk) begin
        if (rst_n && sda_oe !== prev_oe && m_scl) hi_changes++;
        if (sda_oe) oe_seen = 1'b1;
        prev_oe = sda_oe;
    end

    task automatic check(input logic ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wq(input int n = 1);
        repeat (n * Q) @(posedge clk);
        #1;
    endtask

    task automatic bus_start();
        m_sda = 1'b1; wq(); m_scl = 1'b1; wq(); m_sda = 1'b0; wq(); m_scl = 1'b0; wq();
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; wq(); m_scl = 1'b1; wq(); m_sda = 1'b1; wq();
    endtask

    task automatic put_bit(input logic b);
        m_sda = b; wq(); m_scl = 1'b1; wq(2); m_scl = 1'b0; wq();
    endtask

    task automatic put_byte(input logic [7:0] b, output logic acked);
        for (int i = 7; i >= 0; i--) put_bit(b[i]);
        m_sda = 1'b1; wq(); m_scl = 1'b1; wq();
        acked = (sda_bus == 1'b0);
        wq(); m_scl = 1'b0; wq();
    endtask

    task automatic get_byte(input logic give_ack, output logic [7:0] b);
        for (int i = 7; i >= 0; i--) begin
            m_sda = 1'b1; wq(); m_scl = 1'b1; wq();
            b[i] = sda_bus;
            wq(); m_scl = 1'b0; wq();
        end
        m_sda = give_ack ? 1'b0 : 1'b1;
        wq(); m_scl = 1'b1; wq(2); m_scl = 1'b0; wq();
        m_sda = 1'b1;
    endtask

    task automatic set_address(input logic [7:0] hi, input logic [7:0] lo, input string tag);
        logic a;
        bus_start();
        put_byte(DEV_W, a); check(a, {tag, " R1 device ack"}, a, 1);
        put_byte(hi, a);    check(a, {tag, " R4 high byte ack"}, a, 1);
        put_byte(lo, a);    check(a, {tag, " R4 low byte ack"}, a, 1);
    endtask

    task automatic read_run(input int n, input int first, input string tag);
        logic a;
        logic [7:0] b;
        bus_start();
        put_byte(DEV_R, a); check(a, {tag, " R1 read ack"}, a, 1);
        for (int k = 0; k < n; k++) begin
            get_byte(k != n - 1, b);
            check(b == regval((first + k) % NREGS), {tag, " data R5 R11"},
                  b, regval((first + k) % NREGS));
        end
        bus_stop();
    endtask

    task automatic t_reset();
        check(sda_oe == 1'b0, "R3 reset releases SDA", sda_oe, 0);
        check(reg_addr == '0, "R3 reset address", reg_addr, 0);
    endtask

    task automatic t_random();
        set_address(8'hA5, 8'h2C, "random");
        read_run(1, 8'h2C % NREGS, "R5 random");
    endtask

    task automatic t_set_current();
        set_address(8'h00, 8'h13, "setcur");
        bus_stop();
        check(sda_oe == 1'b0, "R3 stop standby", sda_oe, 0);
        read_run(1, 8'h13, "R6 current read");
    endtask

    task automatic t_sequential();
        set_address(8'h00, 8'h0A, "seq");
        read_run(4, 10, "R7 sequential");
    endtask

    task automatic t_wrap();
        set_address(8'hFF, 8'hFE, "wrap");
        read_run(4, 62, "R8 wrap");
    endtask

    task automatic t_mismatch();
        logic a;
        logic [7:0] b;
        bus_start();
        put_byte(8'hDC, a);
        check(!a, "R1 wrong address not acked", a, 0);
        oe_seen = 1'b0;
        get_byte(1'b0, b);
        check(!oe_seen && b == 8'hFF, "R1 silent after mismatch", b, 8'hFF);
        bus_stop();
    endtask

    task automatic t_nack_end();
        logic [7:0] b;
        set_address(8'h00, 8'h05, "nack");
        begin
            logic a;
            bus_start();
            put_byte(DEV_R, a);
        end
        get_byte(1'b0, b);
        check(b == regval(5), "R9 byte before nack", b, regval(5));
        oe_seen = 1'b0;
        get_byte(1'b1, b);
        check(!oe_seen && b == 8'hFF, "R9 no drive after nack", b, 8'hFF);
        bus_stop();
    endtask

    task automatic t_restart();
        bus_start();
        put_bit(1'b1); put_bit(1'b1); put_bit(1'b0);
        set_address(8'h00, 8'h21, "R2 restart");
        read_run(1, 8'h21, "R2 after restart");
    endtask

    initial begin
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        wq();
        t_reset();
        t_random();
        t_set_current();
        t_sequential();
        t_wrap();
        t_mismatch();
        t_nack_end();
        t_restart();
        check(hi_changes == 0, "R10 drive change while SCL high", hi_changes, 0);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule